// File: doc/BRIEF.md
# Constant Off-Time PWM Current Chopper

This block limits the phase current of a brushless motor bridge when the drive runs in pulse-width mode. A comparator outside the block reports when the sensed current has climbed to its target. The block then raises a chop signal that forces the active upper switch off. The lower switch of the driven phase is never touched.

The chop interval is a one-shot of fixed length, counted on the system clock from a programmable cycle count. When it expires, the upper switch conducts again. Every time the upper switch turns on, a blanking window starts, and the comparator is ignored during it. Without this window, the current spike at turn-on would start a new off-time at once.

A mode bit, produced from comparing two reference levels, chooses between pulse-width and linear regulation. In linear mode the block never chops. When the commutation logic withdraws its gate-enable request, the block goes idle and clears both interval counters.

Top module: `pwm_chopper`

## Requirements
- R1: While `rst` is high, `chop` is 0 after every clock edge, whatever the other inputs are.
- R2: A clock edge that samples `gate_en` at 0 leaves `chop` at 0 and clears all timing. The next edge that samples the block active (`gate_en` = 1 and `pwm_mode` = 1) counts as a fresh upper turn-on and starts a new blanking window.
- R3: `pwm_mode` = 1 selects pulse-width mode and 0 selects linear mode. An edge that samples 0 drives `chop` to 0, and this ends any off-time in progress. `chop` stays 0 for as long as linear mode holds.
- R4: Outside the off-time and the blanking window, an edge that samples `oc_trip` = 1 while the block is active drives `chop` to 1 (1 means the upper switch is held off).
- R5: `chop` stays at 1 for exactly `toff_cycles` clock cycles. A value of 0 is treated as 1. The edge that lowers `chop` is an upper turn-on.
- R6: `oc_trip` sampled during the off-time neither lengthens nor restarts it.
- R7: `oc_trip` is ignored at the turn-on edge and at the `BLANK_CYCLES` edges that follow it.
- R8: The off-time length is taken from `toff_cycles` at the edge that trips. A change to `toff_cycles` during the off-time has no effect on that off-time.
- R9: `oc_trip` = 1 at the first edge after the blanking window (turn-on edge + `BLANK_CYCLES` + 1) raises `chop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en | input | 1 | Gate-enable request from the commutation logic |
| pwm_mode | input | 1 | 1 = pulse-width mode, 0 = linear mode |
| oc_trip | input | 1 | Comparator result: sensed current at or above target |
| toff_cycles | input | TOFF_W | Off-time length in clock cycles |
| chop | output | 1 | Registered; 1 holds the active upper switch off |

## Verification
The assertions assume that `oc_trip`, `gate_en` and `pwm_mode` are already synchronous to `clk`. They also assume that `toff_cycles` only needs to be valid at the trip edge. The stimulus changes every input on the falling clock edge, so each rising edge samples one settled value. The stimulus holds `oc_trip` high through off-times and blanking windows on purpose, so that the masking rules meet the worst case. It also drops `pwm_mode` and `gate_en` in the middle of an off-time and in the middle of a blanking window.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_RUN   = 2'd2,
    ST_CUT   = 2'd3
  } chop_st_e;
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R5: an expired counter stays at zero until it is loaded again
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && expired) |=> expired);
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
  import chop_pkg::*;
#(
  parameter int TOFF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              oc_trip,
  input  logic [TOFF_W-1:0] toff_cycles,
  input  logic              blank_done,
  input  logic              off_done,
  output logic              tmr_clr,
  output logic              blank_load,
  output logic              off_load,
  output logic [TOFF_W-1:0] off_val,
  output logic              chop
);
  chop_st_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    blank_load = 1'b0;
    off_load   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        st_d       = ST_BLANK;
        blank_load = 1'b1;
      end
      ST_BLANK: if (blank_done) st_d = ST_RUN;
      ST_RUN: if (oc_trip) begin
        st_d     = ST_CUT;
        off_load = 1'b1;
      end
      ST_CUT: if (off_done) begin
        st_d       = ST_BLANK;
        blank_load = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (!active) begin
      st_d       = ST_IDLE;
      blank_load = 1'b0;
      off_load   = 1'b0;
    end
  end

  assign tmr_clr = !active;
  assign off_val = (toff_cycles == '0) ? '0 : toff_cycles - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      chop <= 1'b0;
    end else begin
      st_q <= st_d;
      chop <= (st_d == ST_CUT);
    end
  end

  // R2: gate withdrawn -> idle, chop released
  p_gate_release_r2: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!chop && st_q == ST_IDLE));
  // R4: a trip in the run phase raises chop
  p_trip_chop_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && active && oc_trip) |=> chop);
  // R7: no chop can follow a blanking cycle
  p_blank_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BLANK) |=> !chop);
  // R6: expiry ends the off-time even with the comparator still high
  p_off_end_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CUT && off_done && active) |=> (!chop && st_q == ST_BLANK));
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper #(
  parameter int TOFF_W       = 16,
  parameter int BLANK_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate_en,
  input  logic              pwm_mode,
  input  logic              oc_trip,
  input  logic [TOFF_W-1:0] toff_cycles,
  output logic              chop
);
  localparam int BLK_W = $clog2(BLANK_CYCLES + 1);
  localparam logic [BLK_W-1:0] BLK_LOAD = BLK_W'(BLANK_CYCLES - 1);

  logic              active;
  logic              tmr_clr, blank_load, off_load;
  logic              blank_done, off_done;
  logic [TOFF_W-1:0] off_val;

  assign active = gate_en & pwm_mode;

  chop_fsm #(.TOFF_W(TOFF_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .active     (active),
    .oc_trip    (oc_trip),
    .toff_cycles(toff_cycles),
    .blank_done (blank_done),
    .off_done   (off_done),
    .tmr_clr    (tmr_clr),
    .blank_load (blank_load),
    .off_load   (off_load),
    .off_val    (off_val),
    .chop       (chop)
  );

  chop_timer #(.W(BLK_W)) u_blank (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .load    (blank_load),
    .load_val(BLK_LOAD),
    .expired (blank_done)
  );

  chop_timer #(.W(TOFF_W)) u_off (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .load    (off_load),
    .load_val(off_val),
    .expired (off_done)
  );

  // R3: linear mode never leaves chop asserted
  p_linear_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !pwm_mode |=> !chop);
  // R1: reset clears the output
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !chop);
endmodule

// File: tb/tb_pwm_chopper.sv
module tb_pwm_chopper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gate_en = 1'b0;
  logic        pwm_mode = 1'b0;
  logic        oc_trip = 1'b0;
  logic [15:0] toff_cycles = 16'd5;
  logic        chop;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t q[$];
  item_t it;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_chopper dut (
    .clk(clk), .rst(rst), .gate_en(gate_en), .pwm_mode(pwm_mode),
    .oc_trip(oc_trip), .toff_cycles(toff_cycles), .chop(chop)
  );

  // monitor: compare each result just after the edge that produced it
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (chop !== it.exp) begin
        fails++;
        $display("FAIL %s: chop actual=%b expected=%b at %0t", it.tag, chop, it.exp, $time);
      end
    end
  end

  task automatic step(input logic r, input logic g, input logic m, input logic o,
                      input logic [15:0] t, input logic e, input string tag);
    @(negedge clk);
    rst = r; gate_en = g; pwm_mode = m; oc_trip = o; toff_cycles = t;
    q.push_back('{e, tag});
  endtask

  initial begin
    // R1: reset dominates
    for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 5, 0, "R1");
    step(0, 0, 1, 1, 5, 0, "R2");
    // turn-on edge, then blanking window with comparator high (R7)
    step(0, 1, 1, 1, 5, 0, "R7");
    for (int i = 0; i < 8; i++) step(0, 1, 1, 1, 5, 0, "R7");
    step(0, 1, 1, 1, 5, 1, "R4");
    for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 5, 1, "R6");
    step(0, 1, 1, 1, 5, 0, "R5");
    for (int i = 0; i < 8; i++) step(0, 1, 1, 1, 5, 0, "R7");
    step(0, 1, 1, 1, 5, 1, "R9");
    // toff changed mid off-time: still 5 cycles (R8)
    for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 2, 1, "R8");
    step(0, 1, 1, 1, 2, 0, "R8");
    // comparator low through blanking and beyond
    for (int i = 0; i < 9; i++) step(0, 1, 1, 0, 2, 0, "R7");
    step(0, 1, 1, 1, 2, 1, "R4");
    // linear mode releases the off-time and stays quiet (R3)
    step(0, 1, 0, 1, 2, 0, "R3");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 2, 0, "R3");
    step(0, 1, 1, 1, 2, 0, "R3");
    for (int i = 0; i < 8; i++) step(0, 1, 1, 1, 2, 0, "R7");
    step(0, 1, 1, 1, 2, 1, "R9");
    step(0, 1, 1, 1, 2, 1, "R5");
    step(0, 1, 1, 1, 2, 0, "R5");
    // gate withdrawn mid-blank, then a fresh window (R2)
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 2, 0, "R2");
    step(0, 1, 1, 1, 0, 0, "R2");
    for (int i = 0; i < 8; i++) step(0, 1, 1, 1, 0, 0, "R2");
    // zero off-time behaves as one cycle (R5)
    step(0, 1, 1, 1, 0, 1, "R5");
    step(0, 1, 1, 0, 0, 0, "R5");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule